// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block turns a digitized supply-low flag and a software watchdog strobe into a processor reset, a watchdog fault flag and a gated chip-enable. It runs from a fast system clock but keeps time with a slow timebase tick pulse. All of its timers advance only on that tick. The reset pulse width and the watchdog timeout are both parameters counted in ticks.

A low supply asserts reset at once and clears the watchdog timer. When the supply recovers, reset is held for a fixed number of ticks before it releases. The watchdog input passes through a two-flop synchronizer. Any edge on it, rising or falling, counts as service. If the input stays at one level for a full timeout, the controller drops the watchdog flag and starts a reset pulse. As long as the watchdog is not serviced, it starts a new reset pulse every timeout period. A separate input that reports a floating watchdog pin turns the watchdog off.

Top module: `sup_rst_wdog`

## Requirements
- R1: Once `supply_low` is 1 at a clock edge, `rst_out_n` is 0 after that edge. It stays 0 for as long as `supply_low` stays 1.
- R2: `supply_low` clears, and then `rst_out_n` returns to 1 at the edge that samples the PULSE_TICKS-th `tick` pulse counted from that point. It never returns to 1 without a `tick` pulse at that edge.
- R3: A rising or a falling change of `wd_in` restarts the watchdog count. The controller sees the change at the third clock edge after the change: two edges for synchronization and one for edge detection.
- R4: If no edge on `wd_in` is detected for WDOG_TICKS tick pulses, `wd_out_n` and `rst_out_n` both go to 0 at the same edge. Reset is then held for PULSE_TICKS ticks. A detected edge that lands on the same clock edge as the expiry prevents the fault.
- R5: If the watchdog stays unserviced, a new reset pulse begins every WDOG_TICKS ticks, counted from the previous fault. `wd_out_n` stays 0 between these pulses.
- R6: While `wd_float` is 1, the watchdog count is held at zero and no watchdog fault occurs.
- R7: `wd_out_n` returns to 1 at the edge where a `wd_in` change is detected. It also returns to 1 at the first edge with `supply_low` at 1.
- R8: `rst_out` is always the inverse of `rst_out_n`.
- R9: `ce_out_n` equals `ce_in_n` when `supply_low` is 0. It is 1 when `supply_low` is 1. The path is combinational.
- R10: While `rst_n` is 0, `rst_out_n` is 0 and `wd_out_n` is 1. After `rst_n` rises, the reset pulse count runs as in R2, and the watchdog count starts from zero.
- R11: While `supply_low` is 1, the watchdog count is held at zero. With `wd_in` held still, the first fault after recovery comes at the WDOG_TICKS-th tick after `supply_low` clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low controller reset |
| tick | input | 1 | One-cycle timebase pulse that advances both timers |
| supply_low | input | 1 | Digitized low-supply flag, active high |
| wd_in | input | 1 | Watchdog strobe level, asynchronous |
| wd_float | input | 1 | High when the watchdog input is reported floating |
| ce_in_n | input | 1 | Active-low chip-enable request |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high copy of the reset |
| wd_out_n | output | 1 | Active-low watchdog fault flag |
| ce_out_n | output | 1 | Gated active-low chip enable |

## Verification
If the pulse counter is wrong, the only place it shows is the edge where `rst_out_n` releases. That edge would come at the wrong tick, up to PULSE_TICKS ticks after the supply recovers. If the watchdog count is wrong, or the edge detector misses an edge, `wd_out_n` falls at the wrong edge. That fault can stay hidden until the end of a full timeout window. For this reason the bench sweeps the service gap across both sides of the timeout, so the edge exactly on the limit is covered. A stale synchronizer value would show up as a false edge, seen as `wd_out_n` rising without any service.

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog #(
  parameter int PULSE_TICKS = 4,
  parameter int WDOG_TICKS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_low,
  input  logic wd_in,
  input  logic wd_float,
  input  logic ce_in_n,
  output logic rst_out_n,
  output logic rst_out,
  output logic wd_out_n,
  output logic ce_out_n
);
  localparam int PW = $clog2(PULSE_TICKS + 1);
  localparam int WW = $clog2(WDOG_TICKS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PULSE_TICKS - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WDOG_TICKS - 1);

  logic [2:0]    sync_q;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wcnt;
  logic          hold_q;
  logic          wd_q;
  logic          wd_edge;
  logic          wd_clr;
  logic          fire;

  assign wd_edge = sync_q[1] ^ sync_q[2];
  assign wd_clr  = supply_low | wd_float | wd_edge;
  assign fire    = !wd_clr && tick && (wcnt == W_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], wd_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (wd_clr || fire) begin
      wcnt <= '0;
    end else if (tick) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      pcnt   <= '0;
    end else if (supply_low || fire) begin
      hold_q <= 1'b1;
      pcnt   <= '0;
    end else if (hold_q && tick) begin
      if (pcnt == P_LAST) begin
        hold_q <= 1'b0;
        pcnt   <= '0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       wd_q <= 1'b1;
    else if (supply_low || wd_edge)   wd_q <= 1'b1;
    else if (fire)                    wd_q <= 1'b0;
  end

  assign rst_out_n = !hold_q;
  assign rst_out   = hold_q;
  assign wd_out_n  = wd_q;
  assign ce_out_n  = supply_low | ce_in_n;
endmodule

// File: rtl/sup_rst_wdog_props.sv
module sup_rst_wdog_props (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic supply_low,
  input logic wd_in,
  input logic wd_float,
  input logic ce_in_n,
  input logic rst_out_n,
  input logic rst_out,
  input logic wd_out_n,
  input logic ce_out_n
);
  p_low_asserts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !rst_out_n);

  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ($past(tick) && !$past(supply_low)));

  p_fault_with_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_out_n) |-> (!rst_out_n && $past(tick)));

  p_float_no_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_float |=> !$fell(wd_out_n));

  p_low_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> wd_out_n);

  p_inverse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out == !rst_out_n);

  p_ce_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_out_n == (supply_low ? 1'b1 : ce_in_n));
endmodule

bind sup_rst_wdog sup_rst_wdog_props u_props (.*);

// File: tb/sup_rst_wdog_test.sv
module sup_rst_wdog_test;
  localparam int PT = 4;
  localparam int WT = 10;

  logic clk = 1'b0;
  logic rst_n, tick, supply_low, wd_in, wd_float, ce_in_n;
  logic rst_out_n, rst_out, wd_out_n, ce_out_n;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sup_rst_wdog #(.PULSE_TICKS(PT), .WDOG_TICKS(WT)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(supply_low),
    .wd_in(wd_in), .wd_float(wd_float), .ce_in_n(ce_in_n),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_out_n(wd_out_n),
    .ce_out_n(ce_out_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      chk("R8", rst_out, !rst_out_n);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: timeout, got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen_low;
    rst_n = 0; tick = 1; supply_low = 0; wd_in = 0; wd_float = 0; ce_in_n = 1;
    cyc(3);
    chk("R10", rst_out_n, 1'b0);
    chk("R10", wd_out_n, 1'b1);
    rst_n = 1;
    cyc(PT - 1);
    chk("R10", rst_out_n, 1'b0);
    cyc(1);
    chk("R10", rst_out_n, 1'b1);
    cyc(WT - PT - 1);
    chk("R4", wd_out_n, 1'b1);
    cyc(1);
    chk("R4", wd_out_n, 1'b0);
    chk("R4", rst_out_n, 1'b0);
    cyc(PT - 1);
    chk("R4", rst_out_n, 1'b0);
    cyc(1);
    chk("R4", rst_out_n, 1'b1);
    cyc(WT - PT - 1);
    chk("R5", rst_out_n, 1'b1);
    chk("R5", wd_out_n, 1'b0);
    cyc(1);
    chk("R5", rst_out_n, 1'b0);

    wd_in = ~wd_in;
    cyc(2);
    chk("R3", wd_out_n, 1'b0);
    cyc(1);
    chk("R7", wd_out_n, 1'b1);

    supply_low = 1;
    #1;
    chk("R9", ce_out_n, 1'b1);
    cyc(3);
    chk("R1", rst_out_n, 1'b0);
    supply_low = 0;
    cyc(PT - 1);
    chk("R2", rst_out_n, 1'b0);
    cyc(1);
    chk("R2", rst_out_n, 1'b1);
    cyc(WT - PT - 1);
    chk("R11", wd_out_n, 1'b1);
    cyc(1);
    chk("R11", wd_out_n, 1'b0);

    supply_low = 1;
    cyc(1);
    chk("R7", wd_out_n, 1'b1);
    chk("R1", rst_out_n, 1'b0);
    tick = 0;
    supply_low = 0;
    cyc(20);
    chk("R2", rst_out_n, 1'b0);
    for (int i = 0; i < PT; i++) begin
      chk("R2", rst_out_n, 1'b0);
      tick = 1;
      cyc(1);
      tick = 0;
      cyc(2);
    end
    chk("R2", rst_out_n, 1'b1);
    tick = 1;

    wd_in = ~wd_in;
    cyc(3);
    for (int g = 1; g <= WT + 2; g++) begin
      seen_low = 0;
      wd_in = ~wd_in;
      for (int k = 0; k < g; k++) begin
        cyc(1);
        if (!wd_out_n) seen_low = 1;
      end
      wd_in = ~wd_in;
      for (int k = 0; k < 3; k++) begin
        cyc(1);
        if (k < 2 && !wd_out_n) seen_low = 1;
      end
      chk("R3", seen_low, (g > WT));
      chk("R7", wd_out_n, 1'b1);
    end

    wd_float = 1;
    seen_low = 0;
    for (int k = 0; k < 3 * WT; k++) begin
      cyc(1);
      if (!wd_out_n) seen_low = 1;
    end
    chk("R6", seen_low, 1'b0);
    wd_float = 0;
    wd_in = ~wd_in;
    cyc(3);

    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 2; c++) begin
        supply_low = s[0];
        ce_in_n = c[0];
        #1;
        chk("R9", ce_out_n, s[0] ? 1'b1 : c[0]);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule